// File: doc/BRIEF.md
# Mode-Configurable Dual/Single Decoder with Selectable Output Polarity

This block is a purely combinational address decoder with eight data outputs. A mode input sets how it works. With the mode input LOW it is two independent 1-of-4 decoders. The low half drives outputs 0 to 3 and the high half drives outputs 4 to 7. Each half has its own two-bit address and its own pair of active-LOW enables. With the mode input HIGH the two halves act as one 1-of-8 decoder. A three-bit address then selects exactly one of the eight outputs.

The output level of each half is configurable. Each half has its own invert input, and a common invert input applies to both halves. A half is active-LOW when either its own invert input or the common one is HIGH. Otherwise it is active-HIGH. An unconnected input is treated as tied to 0. With every input at 0, the block is a pair of enabled, active-HIGH 1-of-4 decoders, both at address 0.

Top module: `decsel_top`

## Requirements
- R1: With `single_mode`=0 and `en_a_n`=2'b00, the low half asserts only output `z[addr_a[1:0]]` among `z[3:0]`.
- R2: With `single_mode`=0 and `en_b_n`=2'b00, the high half asserts only output `z[4+addr_b]` among `z[7:4]`.
- R3: With `single_mode`=1, the address is `n = {addr_a[2], addr_a[1], addr_a[0]}`. Output `z[n]` is asserted when both enables of the half that contains n are LOW. The low half contains n = 0 to 3 and the high half contains n = 4 to 7. Every other output is inactive.
- R4: A half with either of its enables HIGH holds all four of its outputs at the inactive level. `en_a_n` gates `z[3:0]` and `en_b_n` gates `z[7:4]`.
- R5: At most one output is asserted per half. In single mode, at most one output is asserted in total.
- R6: The low half is active-LOW when `pol_lo | pol_all` is 1, and the high half is active-LOW when `pol_hi | pol_all` is 1. Otherwise a half is active-HIGH. An asserted output takes the active level and every other output takes the opposite level.
- R7: In dual mode, `addr_a[2]` has no effect on any output. In single mode, `addr_b` has no effect on any output.
- R8: The outputs follow the inputs with no clock. With every input at 0, `z` equals 8'h11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_a | input | 3 | Low-half address; bit 2 is used in single mode only |
| addr_b | input | 2 | High-half address, used in dual mode only |
| en_a_n | input | 2 | Active-LOW enables of the low half |
| en_b_n | input | 2 | Active-LOW enables of the high half |
| single_mode | input | 1 | 1 selects one 1-of-8 decoder, 0 selects two 1-of-4 decoders |
| pol_lo | input | 1 | Makes the low half active-LOW |
| pol_hi | input | 1 | Makes the high half active-LOW |
| pol_all | input | 1 | Makes both halves active-LOW |
| z | output | 8 | Decoded outputs |

## Verification
The decoder is driven through all 8192 combinations of its thirteen input bits, and each result is compared with an independent model. The sweep covers every address in both modes, with each half enabled and disabled on its own. This tells a wrong mode selection apart from a wrong enable gating, because a single disabled half must stay inactive while the other half keeps decoding. Every address also appears under all eight polarity settings. This separates a missing common invert from a swapped per-half invert. Vectors in which the ignored inputs (`addr_a[2]` in dual mode, `addr_b` in single mode) are nonzero are reported separately, so that a leak from an ignored input shows up under its own requirement.

// File: rtl/decsel_pkg.sv
package decsel_pkg;
  localparam int HALF_AW   = 2;
  localparam int HALF_N    = 1 << HALF_AW;
  localparam int NUM_HALF  = 2;
  localparam int EN_PER_HALF = 2;

  // One-hot vector of a given width from an index.
  function automatic logic [HALF_N-1:0] idx_to_hot(input logic [HALF_AW-1:0] idx);
    logic [HALF_N-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/decsel_route.sv
// Mode steering: picks, per half, the lane index and the half-select gate.
module decsel_route #(
  parameter int AW = decsel_pkg::HALF_AW
) (
  input  logic [AW:0]   addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic          single_mode,
  output logic [AW-1:0] lane_lo,
  output logic [AW-1:0] lane_hi,
  output logic          gate_lo,
  output logic          gate_hi
);
  logic top_bit;

  always_comb begin
    top_bit = addr_lo[AW];
    lane_lo = addr_lo[AW-1:0];
    if (single_mode) begin
      lane_hi = addr_lo[AW-1:0];
      gate_lo = ~top_bit;
      gate_hi = top_bit;
    end else begin
      lane_hi = addr_hi;
      gate_lo = 1'b1;
      gate_hi = 1'b1;
    end
  end
endmodule

// File: rtl/decsel_half_dec.sv
// One 1-of-N decoder half with active-LOW enables and a select gate.
module decsel_half_dec #(
  parameter int AW   = decsel_pkg::HALF_AW,
  parameter int EN_W = decsel_pkg::EN_PER_HALF
) (
  input  logic [AW-1:0]      lane,
  input  logic [EN_W-1:0]    en_n,
  input  logic               gate,
  output logic [(1<<AW)-1:0] hot
);
  localparam int N = 1 << AW;
  logic live;

  always_comb begin
    live = gate & ~(|en_n);
    for (int i = 0; i < N; i++) begin
      hot[i] = live & (lane == AW'(i));
    end
  end
endmodule

// File: rtl/decsel_polarity.sv
// Applies the effective output level of one half.
module decsel_polarity #(
  parameter int N = decsel_pkg::HALF_N
) (
  input  logic [N-1:0] hot,
  input  logic         own_inv,
  input  logic         common_inv,
  output logic [N-1:0] zo
);
  logic inv;

  always_comb begin
    inv = own_inv | common_inv;
    zo  = hot ^ {N{inv}};
  end
endmodule

// File: rtl/decsel_top.sv
module decsel_top #(
  parameter int HALF_AW = decsel_pkg::HALF_AW,
  parameter int EN_W    = decsel_pkg::EN_PER_HALF
) (
  input  logic [HALF_AW:0]                addr_a,
  input  logic [HALF_AW-1:0]              addr_b,
  input  logic [EN_W-1:0]                 en_a_n,
  input  logic [EN_W-1:0]                 en_b_n,
  input  logic                            single_mode,
  input  logic                            pol_lo,
  input  logic                            pol_hi,
  input  logic                            pol_all,
  output logic [2*(1<<HALF_AW)-1:0]       z
);
  localparam int N     = 1 << HALF_AW;
  localparam int HALVES = decsel_pkg::NUM_HALF;

  logic [HALVES-1:0][HALF_AW-1:0] lane;
  logic [HALVES-1:0]              gate;
  logic [HALVES-1:0][EN_W-1:0]    en_n;
  logic [HALVES-1:0]              own_inv;
  logic [HALVES-1:0][N-1:0]       hot;
  logic [HALVES-1:0][N-1:0]       zh;

  decsel_route #(.AW(HALF_AW)) u_route (
    .addr_lo     (addr_a),
    .addr_hi     (addr_b),
    .single_mode (single_mode),
    .lane_lo     (lane[0]),
    .lane_hi     (lane[1]),
    .gate_lo     (gate[0]),
    .gate_hi     (gate[1])
  );

  assign en_n[0]    = en_a_n;
  assign en_n[1]    = en_b_n;
  assign own_inv[0] = pol_lo;
  assign own_inv[1] = pol_hi;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    decsel_half_dec #(.AW(HALF_AW), .EN_W(EN_W)) u_dec (
      .lane (lane[h]),
      .en_n (en_n[h]),
      .gate (gate[h]),
      .hot  (hot[h])
    );
    decsel_polarity #(.N(N)) u_pol (
      .hot        (hot[h]),
      .own_inv    (own_inv[h]),
      .common_inv (pol_all),
      .zo         (zh[h])
    );
    assign z[h*N +: N] = zh[h];
  end
endmodule

// File: rtl/decsel_checker.sv
module decsel_checker #(
  parameter int HALF_AW = decsel_pkg::HALF_AW,
  parameter int EN_W    = decsel_pkg::EN_PER_HALF
) (
  input logic [HALF_AW:0]          addr_a,
  input logic [HALF_AW-1:0]        addr_b,
  input logic [EN_W-1:0]           en_a_n,
  input logic [EN_W-1:0]           en_b_n,
  input logic                      single_mode,
  input logic                      pol_lo,
  input logic                      pol_hi,
  input logic                      pol_all,
  input logic [2*(1<<HALF_AW)-1:0] z
);
  localparam int N = 1 << HALF_AW;
  logic [N-1:0] act_lo, act_hi;

  always_comb begin
    act_lo = z[N-1:0]   ^ {N{pol_lo | pol_all}};
    act_hi = z[2*N-1:N] ^ {N{pol_hi | pol_all}};

    a_r5_one_per_half: assert ($onehot0(act_lo) && $onehot0(act_hi))
      else $error("R5: more than one output asserted in a half");
    a_r5_one_total: assert (!single_mode || $countones({act_hi, act_lo}) <= 1)
      else $error("R5: more than one output asserted in single mode");
    a_r4_lo_idle: assert (en_a_n == '0 || act_lo == '0)
      else $error("R4: disabled low half asserts an output");
    a_r4_hi_idle: assert (en_b_n == '0 || act_hi == '0)
      else $error("R4: disabled high half asserts an output");
    a_r1_lo_lane: assert (single_mode || en_a_n != '0 || act_lo[addr_a[HALF_AW-1:0]])
      else $error("R1: addressed low output not asserted");
    a_r2_hi_lane: assert (single_mode || en_b_n != '0 || act_hi[addr_b])
      else $error("R2: addressed high output not asserted");
  end
endmodule

bind decsel_top decsel_checker #(.HALF_AW(HALF_AW), .EN_W(EN_W)) u_decsel_chk (.*);

// File: tb/tb_decsel_top.sv
module tb_decsel_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  addr_a;
  logic [1:0]  addr_b;
  logic [1:0]  en_a_n, en_b_n;
  logic        single_mode, pol_lo, pol_hi, pol_all;
  logic [7:0]  z;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { logic [12:0] vec; logic [7:0] exp; } item_t;
  item_t q[$];

  decsel_top dut (
    .addr_a(addr_a), .addr_b(addr_b), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .single_mode(single_mode), .pol_lo(pol_lo), .pol_hi(pol_hi),
    .pol_all(pol_all), .z(z)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector layout: {single_mode, pol_all, pol_hi, pol_lo, en_b_n, en_a_n, addr_b, addr_a}
  function automatic logic [7:0] model(input logic [12:0] v);
    logic [2:0] aa;  logic [1:0] ab, ea, eb;
    logic md, pa, ph, pl, on, hit, inv;
    logic [7:0] r;
    aa = v[2:0]; ab = v[4:3]; ea = v[6:5]; eb = v[8:7];
    pl = v[9]; ph = v[10]; pa = v[11]; md = v[12];
    for (int i = 0; i < 8; i++) begin
      on  = (i < 4) ? (ea == 2'b00) : (eb == 2'b00);
      inv = (i < 4) ? (pl | pa) : (ph | pa);
      if (md) hit = (i == int'(aa));
      else if (i < 4) hit = (i == int'(aa[1:0]));
      else hit = ((i - 4) == int'(ab));
      r[i] = (on & hit) ^ inv;
    end
    return r;
  endfunction

  task automatic apply(input logic [12:0] v);
    {single_mode, pol_all, pol_hi, pol_lo, en_b_n, en_a_n, addr_b, addr_a} = v;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: z=%h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      logic [12:0] v;
      string tl, th, pt;
      logic [7:0] pm;
      it = q.pop_front();
      v  = it.vec;
      pt = (v[11:9] != 3'b000) ? "/R6" : "";
      if (v[6:5] != 2'b00)  tl = "R4";
      else if (v[12])       tl = "R3";
      else if (v[2])        tl = "R7";
      else                  tl = "R1";
      if (v[8:7] != 2'b00)  th = "R4";
      else if (!v[12])      th = "R2";
      else if (v[4:3] != 0) th = "R7";
      else                  th = "R3";
      check({tl, pt, " low half"},  {4'h0, z[3:0]}, {4'h0, it.exp[3:0]});
      check({th, pt, " high half"}, {4'h0, z[7:4]}, {4'h0, it.exp[7:4]});
      pm = {{4{v[10] | v[11]}}, {4{v[9] | v[11]}}};
      check("R5 asserted count", 8'($countones(z ^ pm)), 8'($countones(it.exp ^ pm)));
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, pending=%0d expected 0", q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(13'h0000);
    #1;
    check("R8 all inputs zero", z, 8'h11);
    // R8: outputs follow inputs with no clock edge.
    apply(13'h1006);
    #1;
    check("R8 no-clock update", z, model(13'h1006));
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int v = 0; v < 8192; v++) begin
      item_t it;
      @(negedge clk);
      apply(13'(v));
      it.vec = 13'(v);
      it.exp = model(13'(v));
      q.push_back(it);
    end
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule